// File: doc/BRIEF.md
# Dual-System Quench Interlock Voter

This block merges the quench verdicts of two independent detection systems into one interlock line per magnet coil group. There are eight groups: one toroidal and seven poloidal. Each system supplies, for every group, an alarm line and an inhibit line. A system's inhibit can mask its own alarm for that group. The two masked verdicts are then combined so that a trip from either system is enough to open the group's interlock. Every alarm and interlock line is fail-safe: high means healthy, low means trip. A cut wire therefore reads as a trip.

Each interlock output is registered and latches open once it trips. It closes again only when a rearm request arrives while that group's inputs are healthy. A combined poloidal interlock opens when any poloidal group opens. Each interlock drives a relay whose five contacts are read back. Each group has its own monitor that compares the commanded level with the AND of the group's contacts and raises a sticky fault if the two disagree for too long. A single status output summarises the whole block.

Top module: `qd_interlock_voter`

## Requirements
- R1: There are eight channels. Bit 0 of every per-channel vector is the toroidal group, and bits 1 to 7 are poloidal groups 1 to 7.
- R2: A system's verdict for a channel counts as healthy when its alarm line is high or its inhibit line is low. A low inhibit therefore masks that system's alarm on that channel only.
- R3: A channel's vote is a trip when the masked verdict of system A, of system B, or of both is a trip.
- R4: When a channel's vote is a trip at a clock edge, that channel's interlock output is low after that edge.
- R5: A tripped interlock stays low until `rearm` is sampled high at an edge where that channel's vote is healthy. A rearm given while the vote is still a trip has no effect.
- R6: While the synchronous active-high `rst` is sampled high, all interlock outputs go low and all fault flags clear.
- R7: `pf_intlk` is low whenever any of interlock bits 7 to 1 is low, and high when all of them are high. Interlock bit 0 has no effect on it.
- R8: The readback for channel i is the AND of the five contact bits `relay_rb[5*i +: 5]`. One low contact makes the readback low.
- R9: If the readback differs from the interlock output of its channel at three consecutive edges, `fault[i]` rises at the third edge. A mismatch lasting two edges raises no fault. A fault stays high until `rst`.
- R10: `status_ok` is high exactly when all eight interlocks are high and no fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm | input | 1 | Request to close tripped interlocks whose vote is healthy |
| a_alarm | input | 8 | System A alarm per channel, low = trip |
| a_inhib | input | 8 | System A inhibit per channel, low = mask alarm |
| b_alarm | input | 8 | System B alarm per channel, low = trip |
| b_inhib | input | 8 | System B inhibit per channel, low = mask alarm |
| relay_rb | input | 40 | Relay contact readback, five bits per channel |
| intlk | output | 8 | Per-channel interlock, low = open (tripped) |
| pf_intlk | output | 1 | Combined poloidal interlock, low = open |
| fault | output | 8 | Sticky readback-mismatch fault per channel |
| status_ok | output | 1 | All interlocks closed and no fault |

## Verification
The bench targets several corner cases, each tied to a specific wrong design.

- **Inhibit masking.** One system masks its own alarm while the other system then trips. A design that shared the mask between systems would stay closed.
- **Rearm while tripping.** Rearm is held while an alarm is still low. A design that treated rearm as an override would close into a live trip.
- **Fault window.** Mismatches of exactly two and exactly three edges are applied. An off-by-one counter would fault on the short one or miss the long one.
- **Partial contact readback.** With the interlock open, only four of the five contacts are stuck high. A design that ORed the contacts instead of ANDing them would flag a false fault.
- **Toroidal trip.** A toroidal-only trip must leave the poloidal summary closed.

// File: rtl/qdv_pkg.sv
package qdv_pkg;

    localparam int N_CH     = 8;   // channel 0 toroidal, 1..7 poloidal
    localparam int RB_W     = 5;   // relay contacts read back per channel
    localparam int MM_LIMIT = 2;   // mismatch edges tolerated before a fault

    typedef logic [N_CH-1:0] ch_vec_t;

    // Masked verdict of one system for one channel: high = healthy.
    typedef struct packed {
        logic ok_a;
        logic ok_b;
    } vote_pair_t;

    // Inhibit low forces the verdict healthy; otherwise the alarm passes.
    function automatic logic masked_ok(input logic alarm, input logic inhib);
        return alarm | ~inhib;
    endfunction

endpackage

// File: rtl/qdv_bypass.sv
module qdv_bypass
    import qdv_pkg::*;
#(
    parameter int N = N_CH
) (
    input  logic [N-1:0] alarm,
    input  logic [N-1:0] inhib,
    output logic [N-1:0] ok
);

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign ok[i] = masked_ok(alarm[i], inhib[i]);
    end

endmodule

// File: rtl/qdv_vote_latch.sv
module qdv_vote_latch
    import qdv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rearm,
    input  vote_pair_t vp,
    output logic       intlk_q
);

    logic vote_ok;

    assign vote_ok = vp.ok_a & vp.ok_b;   // 1oo2 on trip-low lines

    always_ff @(posedge clk) begin
        if (rst) begin
            intlk_q <= 1'b0;
        end else if (!vote_ok) begin
            intlk_q <= 1'b0;
        end else if (rearm) begin
            intlk_q <= 1'b1;
        end
    end

    // R4: a trip from either system opens the interlock at the next edge
    a_r4_trip_opens: assert property (@(posedge clk) disable iff (rst)
        (!vp.ok_a || !vp.ok_b) |=> !intlk_q);

    // R5: an open interlock stays open without rearm
    a_r5_hold_open: assert property (@(posedge clk) disable iff (rst)
        (!intlk_q && !rearm) |=> !intlk_q);

    // R5: closing needs rearm together with a healthy vote
    a_r5_close_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(intlk_q) |-> $past(rearm && vp.ok_a && vp.ok_b));

endmodule

// File: rtl/qdv_rb_monitor.sv
module qdv_rb_monitor
    import qdv_pkg::*;
#(
    parameter int W   = RB_W,
    parameter int LIM = MM_LIMIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd,
    input  logic [W-1:0] contacts,
    output logic         fault_q
);

    localparam int CW = $clog2(LIM + 1);

    logic          rb_level;
    logic          mismatch;
    logic [CW-1:0] run_q;

    assign rb_level = &contacts;
    assign mismatch = rb_level ^ cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (!mismatch) begin
                run_q <= '0;
            end else if (run_q != CW'(LIM)) begin
                run_q <= run_q + 1'b1;
            end
            if (mismatch && run_q == CW'(LIM)) begin
                fault_q <= 1'b1;
            end
        end
    end

    // R9: a fault, once raised, holds until reset
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);

    // R9: a fault only rises on an edge where a mismatch was seen
    a_r9_fault_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> $past(mismatch));

endmodule

// File: rtl/qd_interlock_voter.sv
module qd_interlock_voter
    import qdv_pkg::*;
#(
    parameter int N   = N_CH,
    parameter int W   = RB_W,
    parameter int LIM = MM_LIMIT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rearm,
    input  logic [N-1:0]   a_alarm,
    input  logic [N-1:0]   a_inhib,
    input  logic [N-1:0]   b_alarm,
    input  logic [N-1:0]   b_inhib,
    input  logic [N*W-1:0] relay_rb,
    output logic [N-1:0]   intlk,
    output logic           pf_intlk,
    output logic [N-1:0]   fault,
    output logic           status_ok
);

    logic [N-1:0] ok_a;
    logic [N-1:0] ok_b;

    qdv_bypass #(.N(N)) u_mask_a (.alarm(a_alarm), .inhib(a_inhib), .ok(ok_a));
    qdv_bypass #(.N(N)) u_mask_b (.alarm(b_alarm), .inhib(b_inhib), .ok(ok_b));

    for (genvar i = 0; i < N; i++) begin : g_ch
        vote_pair_t vp;
        assign vp.ok_a = ok_a[i];
        assign vp.ok_b = ok_b[i];

        qdv_vote_latch u_vote (
            .clk     (clk),
            .rst     (rst),
            .rearm   (rearm),
            .vp      (vp),
            .intlk_q (intlk[i])
        );

        qdv_rb_monitor #(.W(W), .LIM(LIM)) u_mon (
            .clk      (clk),
            .rst      (rst),
            .cmd      (intlk[i]),
            .contacts (relay_rb[i*W +: W]),
            .fault_q  (fault[i])
        );
    end

    // Channel 0 is toroidal; the rest form the poloidal summary.
    assign pf_intlk  = &intlk[N-1:1];
    assign status_ok = (&intlk) & ~(|fault);

    // R6: the cycle after a sampled reset shows every interlock open
    a_r6_reset_opens: assert property (@(posedge clk)
        rst |=> (intlk == '0 && fault == '0));

endmodule

// File: tb/qd_interlock_voter_bench.sv
module qd_interlock_voter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int W = 5;

    logic           clk = 1'b0;
    logic           rst;
    logic           rearm;
    logic [N-1:0]   a_alarm, a_inhib, b_alarm, b_inhib;
    logic [N*W-1:0] relay_rb;
    logic [N*W-1:0] rb_kill, rb_stuck;
    logic [N-1:0]   intlk, fault;
    logic           pf_intlk, status_ok;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qd_interlock_voter u_qd_interlock_voter (
        .clk(clk), .rst(rst), .rearm(rearm),
        .a_alarm(a_alarm), .a_inhib(a_inhib),
        .b_alarm(b_alarm), .b_inhib(b_inhib),
        .relay_rb(relay_rb),
        .intlk(intlk), .pf_intlk(pf_intlk),
        .fault(fault), .status_ok(status_ok)
    );

    // Relay model: contacts follow the command unless forced.
    always_comb begin
        for (int k = 0; k < N*W; k++) begin
            relay_rb[k] = (intlk[k/W] & ~rb_kill[k]) | rb_stuck[k];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic healthy();
        a_alarm = '1; b_alarm = '1; a_inhib = '1; b_inhib = '1;
        rb_kill = '0; rb_stuck = '0;
    endtask

    task automatic do_rearm();
        rearm = 1'b1; step(1); rearm = 1'b0;
    endtask

    task automatic t_reset();
        healthy(); rearm = 1'b0; rst = 1'b1;
        step(2);
        chk("R6 intlk open in reset", intlk, 0);
        chk("R6 fault clear in reset", fault, 0);
        chk("R10 status low in reset", status_ok, 0);
        rst = 1'b0; step(2);
        chk("R5 no close without rearm", intlk, 0);
        do_rearm();
        chk("R5 rearm closes all", intlk, 8'hFF);
        chk("R10 status high", status_ok, 1);
        chk("R7 pf closed", pf_intlk, 1);
    endtask

    task automatic t_trip_a();
        a_alarm[3] = 1'b0; step(1);
        chk("R4 R3 system A trip ch3", intlk, 8'hF7);
        chk("R7 pf opens on PF3", pf_intlk, 0);
        a_alarm[3] = 1'b1; step(2);
        chk("R5 latched after alarm clears", intlk, 8'hF7);
        do_rearm();
        chk("R5 rearm after clear", intlk, 8'hFF);
    endtask

    task automatic t_trip_b_toroidal();
        b_alarm[0] = 1'b0; step(1);
        chk("R1 R3 system B trips toroidal bit0", intlk, 8'hFE);
        chk("R7 toroidal has no effect on pf", pf_intlk, 1);
        chk("R10 status low on trip", status_ok, 0);
        b_alarm[0] = 1'b1; do_rearm();
        chk("R5 toroidal rearmed", intlk, 8'hFF);
    endtask

    task automatic t_inhibit();
        a_inhib[5] = 1'b0; a_alarm[5] = 1'b0; step(2);
        chk("R2 masked alarm ignored", intlk, 8'hFF);
        b_alarm[5] = 1'b0; step(1);
        chk("R2 R3 other system still trips", intlk, 8'hDF);
        healthy(); do_rearm();
        chk("R5 rearm after inhibit test", intlk, 8'hFF);
    endtask

    task automatic t_rearm_blocked();
        b_alarm[6] = 1'b0; step(1);
        rearm = 1'b1; step(2);
        chk("R5 rearm ignored while tripping", intlk, 8'hBF);
        b_alarm[6] = 1'b1; step(1); rearm = 1'b0;
        chk("R5 closes once healthy with rearm", intlk, 8'hFF);
    endtask

    task automatic t_readback();
        rb_kill[2*W+1] = 1'b1; step(2); rb_kill = '0; step(1);
        chk("R9 R8 two-edge mismatch no fault", fault, 0);
        rb_kill[2*W+1] = 1'b1; step(3);
        chk("R9 R8 three-edge mismatch faults", fault, 8'h04);
        rb_kill = '0; step(2);
        chk("R9 fault sticky", fault, 8'h04);
        chk("R10 status low on fault", status_ok, 0);
        rst = 1'b1; step(1); rst = 1'b0;
        chk("R6 reset clears fault", fault, 0);
        rb_stuck[4*W +: 4] = 4'hF; step(4);
        chk("R8 one open contact keeps readback low", fault, 0);
        rb_stuck[4*W +: 5] = 5'h1F; step(3);
        chk("R9 stuck-closed relay faults", fault, 8'h10);
        rb_stuck = '0; rst = 1'b1; step(1); rst = 1'b0;
        do_rearm();
        chk("R10 status restored", status_ok, 1);
    endtask

    initial begin
        t_reset();
        t_trip_a();
        t_trip_b_toroidal();
        t_inhibit();
        t_rearm_blocked();
        t_readback();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule